// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receiver

This block takes in the packets of one isochronous OUT endpoint and hands them to a processor. It holds two packet buffers that are used in turn. The USB side streams packet bytes into the buffer next in line and closes each packet with an end-of-packet strobe, which also carries a short-packet hint. The processor pops bytes from a data port, one byte per read strobe, and reads or writes an 8-bit status word.

A packet that starts while its target buffer still holds a committed packet is dropped whole, and an overflow flag is raised. The packet is not refused at the bus. Completion and overflow drive one level interrupt request, which is gated by a receive interrupt enable. A short-packet flag describes the packet in the buffer being read. Together with the not-empty flag it tells the processor when a zero-length packet is waiting.

Status word layout: bit 0 `pkt_done`, bit 1 `ovf`, bit 2 `not_empty`, bit 6 `short`. Bits 3, 4, 5 and 7 are reserved.

Top module: `iso_out_rx`

## Requirements
- R1: When `usb_eop` closes a packet that is not dropped, `pkt_done` (bit 0) reads 1 from the next cycle.
- R2: `ep_irq` equals `rx_ie` AND (`pkt_done` OR `ovf`). With `rx_ie` low, `ep_irq` stays 0 even while status bits are set.
- R3: Bits 0 and 1 clear only when `csr_we` writes 1 to that bit. Writing 0 leaves them as they are. A set event in the same cycle as a clear wins.
- R4: The two buffers are filled alternately. A packet whose first event finds its target buffer still committed is dropped entirely: no byte is stored and `pkt_done` does not change. `ovf` (bit 1) reads 1 after that packet's `usb_eop`.
- R5: Bits 3, 4, 5 and 7 always read 0, whatever is written to them.
- R6: `not_empty` (bit 2) is 1 exactly when the active read buffer holds a committed packet with unread bytes.
- R7: `short` (bit 6) takes the flag of the packet that becomes active. This happens when a packet is committed into an empty active buffer, or when reading moves to the other buffer. It clears on any other commit, and on releasing the active buffer when no other packet waits.
- R8: A packet is flagged short if `usb_short` is high at `usb_eop` or it holds fewer than MAX_PKT bytes. Bytes beyond MAX_PKT are discarded.
- R9: `rd_byte` shows the next unread byte of the active buffer, and `rd_stb` pops it. While no byte is unread, `rd_byte` is 0 and `rd_stb` changes nothing.
- R10: Reading the last byte releases the buffer. Reading then moves to the other buffer at once if it holds a committed packet. Packets are read in commit order. A zero-length active packet is released by writing 1 to bit 0.
- R11: After reset, the status word, `rd_byte` and `ep_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_we | input | 1 | Packet byte valid |
| usb_wbyte | input | 8 | Packet byte |
| usb_eop | input | 1 | End of packet (may coincide with the last byte) |
| usb_short | input | 1 | Short-packet hint sampled at end of packet |
| rd_stb | input | 1 | Pop one byte from the data port |
| rd_byte | output | 8 | Data port: next unread byte |
| csr_we | input | 1 | Status word write strobe |
| csr_wdata | input | 8 | Status write data (write 1 to clear bits 0 and 1) |
| csr_rdata | output | 8 | Status word |
| rx_ie | input | 1 | Receive interrupt enable |
| ep_irq | output | 1 | Endpoint interrupt request |

## Verification
A wrong buffer pointer or fill flag shows up on `rd_byte` in the next cycle: the wrong packet's data comes out, or a 0 appears where a byte was expected. It can also show as a `not_empty` that does not match the queue of committed packets. A stale short flag or a missed release shows up in bit 6 one cycle after the commit or the final read. A wrong drop decision shows up as a spurious or missing `ovf` after the end of the packet. It also surfaces later as packets read out of order. The reference model compares every status bit, the data port and the interrupt on every cycle, so each of these faults is caught within one clock.

// File: rtl/iso_out_rx.sv
module iso_out_rx #(
  parameter int MAX_PKT = 256,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       usb_we,
  input  logic [7:0] usb_wbyte,
  input  logic       usb_eop,
  input  logic       usb_short,
  input  logic       rd_stb,
  output logic [7:0] rd_byte,
  input  logic       csr_we,
  input  logic [7:0] csr_wdata,
  output logic [7:0] csr_rdata,
  input  logic       rx_ie,
  output logic       ep_irq
);

  logic [7:0]    mem [2][MAX_PKT];
  logic [CW-1:0] len [2];
  logic [1:0]    full, sflag;
  logic [CW-1:0] rptr, wcnt;
  logic          rsel, wsel, in_pkt, drop_q;
  logic          done, ovf, short_q;

  wire           drop   = in_pkt ? drop_q : full[wsel];
  wire           wr_ok  = usb_we & ~drop & (wcnt < CW'(MAX_PKT));
  wire [CW-1:0]  wcnt_n = wcnt + CW'(wr_ok);
  wire           commit = usb_eop & ~drop;
  wire           new_sf = usb_short | (wcnt_n < CW'(MAX_PKT));
  wire           ne     = full[rsel] & (rptr != len[rsel]);
  wire           pop    = rd_stb & ne;
  wire           last   = pop & ((rptr + CW'(1)) == len[rsel]);
  wire           zrel   = csr_we & csr_wdata[0] & full[rsel] & (len[rsel] == '0);
  wire           rel    = last | zrel;
  wire           move   = (~full[rsel] | rel) & full[~rsel];

  assign rd_byte   = ne ? mem[rsel][rptr[AW-1:0]] : 8'h00;
  assign csr_rdata = {1'b0, short_q, 3'b000, ne, ovf, done};
  assign ep_irq    = rx_ie & (done | ovf);

  always_ff @(posedge clk)
    if (wr_ok) mem[wsel][wcnt[AW-1:0]] <= usb_wbyte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      drop_q <= 1'b0;
      wcnt   <= '0;
      wsel   <= 1'b0;
      len[0] <= '0;
      len[1] <= '0;
      sflag  <= '0;
    end else begin
      in_pkt <= usb_eop ? 1'b0 : (in_pkt | usb_we);
      drop_q <= drop;
      wcnt   <= usb_eop ? '0 : wcnt_n;
      if (commit) begin
        len[wsel]   <= wcnt_n;
        sflag[wsel] <= new_sf;
        wsel        <= ~wsel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= '0;
      rsel    <= 1'b0;
      rptr    <= '0;
      short_q <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (commit && wsel == b[0]) full[b] <= 1'b1;
        else if (rel && rsel == b[0]) full[b] <= 1'b0;
      end
      if (pop && !last) rptr <= rptr + CW'(1);
      else if (rel)     rptr <= '0;
      if (move) rsel <= ~rsel;
      if (move)                       short_q <= sflag[~rsel];
      else if (commit && wsel == rsel) short_q <= new_sf;
      else if (commit || rel)          short_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (commit) done <= 1'b1;
      else if (csr_we && csr_wdata[0]) done <= 1'b0;
      if (usb_eop && drop) ovf <= 1'b1;
      else if (csr_we && csr_wdata[1]) ovf <= 1'b0;
    end
  end

endmodule

module iso_out_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       usb_eop,
  input logic       in_pkt,
  input logic       drop_q,
  input logic       rd_stb,
  input logic [7:0] rd_byte,
  input logic       csr_we,
  input logic [7:0] csr_wdata,
  input logic [7:0] csr_rdata,
  input logic       rx_ie,
  input logic       ep_irq
);

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[0] && !(csr_we && csr_wdata[0]) |=> csr_rdata[0]);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[1] && !(csr_we && csr_wdata[1]) |=> csr_rdata[1]);

  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt && drop_q && usb_eop |=> csr_rdata[1]);

  assert_irq_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rdata[0]) && rx_ie |-> ep_irq);

  assert_ne_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[2] && !rd_stb |=> csr_rdata[2]);

  assert_empty_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[2] |-> rd_byte == 8'h00);

endmodule

bind iso_out_rx iso_out_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .usb_eop(usb_eop), .in_pkt(in_pkt), .drop_q(drop_q),
  .rd_stb(rd_stb), .rd_byte(rd_byte), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .rx_ie(rx_ie), .ep_irq(ep_irq)
);

// File: tb/sim_iso_out_rx.sv
module sim_iso_out_rx;
  localparam int CLK_P = 10;
  localparam int MAXP  = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic usb_we = 0, usb_eop = 0, usb_short = 0, rd_stb = 0, csr_we = 0, rx_ie = 0;
  logic [7:0] usb_wbyte = 0, csr_wdata = 0;
  logic [7:0] rd_byte, csr_rdata;
  logic ep_irq;

  iso_out_rx #(.MAX_PKT(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .usb_we(usb_we), .usb_wbyte(usb_wbyte), .usb_eop(usb_eop),
    .usb_short(usb_short), .rd_stb(rd_stb), .rd_byte(rd_byte), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rx_ie(rx_ie), .ep_irq(ep_irq));

  always #(CLK_P/2) clk = ~clk;

  int runs = 0, fails = 0;

  task automatic chk(string tag, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: byte queues per buffer
  logic [7:0] mq [2][$];
  logic [7:0] wq [$];
  bit f [2], sh [2];
  bit rs, ws, m_done, m_ovf, m_short, inp, drp;

  function automatic bit m_ne();
    return f[rs] && mq[rs].size() > 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq[0].delete(); mq[1].delete(); wq.delete();
      f[0] = 0; f[1] = 0; sh[0] = 0; sh[1] = 0;
      rs = 0; ws = 0; m_done = 0; m_ovf = 0; m_short = 0; inp = 0; drp = 0;
    end else begin
      bit drop, pop, last, zrel, rel, mv, com, sf, tgt_active, osh_other;
      drop = inp ? drp : f[ws];
      pop  = rd_stb && m_ne();
      last = pop && mq[rs].size() == 1;
      zrel = csr_we && csr_wdata[0] && f[rs] && mq[rs].size() == 0;
      rel  = last || zrel;
      mv   = (!f[rs] || rel) && f[!rs];
      com  = usb_eop && !drop;
      osh_other = sh[!rs];
      tgt_active = (ws == rs);
      if (usb_we && !drop && wq.size() < MAXP) wq.push_back(usb_wbyte);
      sf = usb_short || (wq.size() < MAXP);
      if (pop) void'(mq[rs].pop_front());
      if (rel) f[rs] = 0;
      if (com) begin mq[ws] = wq; f[ws] = 1; sh[ws] = sf; end
      if (mv) m_short = osh_other;
      else if (com && tgt_active) m_short = sf;
      else if (com || rel) m_short = 0;
      if (mv) rs = !rs;
      if (com) ws = !ws;
      if (com) m_done = 1; else if (csr_we && csr_wdata[0]) m_done = 0;
      if (usb_eop && drop) m_ovf = 1; else if (csr_we && csr_wdata[1]) m_ovf = 0;
      inp = usb_eop ? 0 : (inp || usb_we);
      drp = drop;
      if (usb_eop) wq.delete();
    end
  end

  bit live = 0;
  always @(negedge clk) begin
    #1;
    if (live && rst_n) begin
      chk("R1 done",     int'(csr_rdata[0]), int'(m_done));
      chk("R4 ovf",      int'(csr_rdata[1]), int'(m_ovf));
      chk("R6 ne",       int'(csr_rdata[2]), int'(m_ne()));
      chk("R5 reserved", int'({csr_rdata[7], csr_rdata[5:3]}), 0);
      chk("R7 short",    int'(csr_rdata[6]), int'(m_short));
      chk("R9 data",     int'(rd_byte), m_ne() ? int'(mq[rs][0]) : 0);
      chk("R2 irq",      int'(ep_irq), int'(rx_ie && (m_done || m_ovf)));
    end
  end

  task automatic send(int n, bit sf, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); usb_we = 1; usb_wbyte = 8'(seed + i);
    end
    @(negedge clk); usb_we = 0; usb_eop = 1; usb_short = sf;
    @(negedge clk); usb_eop = 0; usb_short = 0;
  endtask

  task automatic rd_n(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rd_stb = 1; end
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic csr_w(logic [7:0] v);
    @(negedge clk); csr_we = 1; csr_wdata = v;
    @(negedge clk); csr_we = 0; csr_wdata = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    #2;
    chk("R11 reset csr", int'(csr_rdata), 0);
    chk("R11 reset data", int'(rd_byte), 0);
    chk("R11 reset irq", int'(ep_irq), 0);
    rx_ie = 1;

    send(5, 0, 8'h10); settle();
    chk("R1 done set", int'(csr_rdata[0]), 1);
    chk("R2 irq", int'(ep_irq), 1);
    chk("R6 ne", int'(csr_rdata[2]), 1);
    chk("R8 short by length", int'(csr_rdata[6]), 1);
    chk("R9 head byte", int'(rd_byte), 8'h10);
    rd_n(5); settle();
    chk("R10 drained", int'(csr_rdata[2]), 0);
    chk("R7 short cleared", int'(csr_rdata[6]), 0);

    csr_w(8'h00); settle();
    chk("R3 write0 keeps done", int'(csr_rdata[0]), 1);
    csr_w(8'h01); settle();
    chk("R3 w1c done", int'(csr_rdata[0]), 0);
    chk("R2 irq low", int'(ep_irq), 0);
    csr_w(8'hF8); settle();
    chk("R5 reserved write", int'(csr_rdata), 0);

    send(MAXP, 0, 8'h40); send(3, 0, 8'hA0); send(2, 0, 8'hC0); settle();
    chk("R4 ovf", int'(csr_rdata[1]), 1);
    chk("R8 full size not short", int'(csr_rdata[6]), 0);
    chk("R10 first packet head", int'(rd_byte), 8'h40);
    rd_n(MAXP); settle();
    chk("R10 moved to second", int'(rd_byte), 8'hA0);
    chk("R7 short of new active", int'(csr_rdata[6]), 1);
    rd_n(3); settle();
    chk("R4 dropped packet absent", int'(csr_rdata[2]), 0);

    send(0, 0, 0); settle();
    chk("R7 zero length short", int'(csr_rdata[6]), 1);
    chk("R6 zero length empty", int'(csr_rdata[2]), 0);
    rd_n(2); settle();
    chk("R9 empty read data", int'(rd_byte), 0);
    chk("R9 empty read no change", int'(csr_rdata[6]), 1);
    csr_w(8'h01); settle();
    chk("R10 zero length released", int'(csr_rdata[6]), 0);
    csr_w(8'h02); settle();
    chk("R3 w1c ovf", int'(csr_rdata), 0);

    send(MAXP + 20, 0, 8'h00); settle();
    chk("R8 oversize not short", int'(csr_rdata[6]), 0);
    rd_n(MAXP); settle();
    chk("R8 oversize truncated", int'(csr_rdata[2]), 0);

    send(MAXP, 1, 8'h55); settle();
    chk("R8 hint marks short", int'(csr_rdata[6]), 1);
    rd_n(MAXP);
    csr_w(8'h03);
    rx_ie = 0;
    send(4, 0, 8'h77); settle();
    chk("R2 gated irq", int'(ep_irq), 0);
    chk("R1 done while gated", int'(csr_rdata[0]), 1);
    rd_n(4); settle();

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule